// File: doc/BRIEF.md
# UART Channel Status-Pin Controller

This block decides the levels of the external status pins for one UART channel. It takes the occupancy of the transmit and receive FIFOs, the programmed receive trigger level, the DMA mode bit, the interrupt-enable bits, modem-control bit 3, a two-bit function select and the 16x baud clock. From these it produces the interrupt pin and its output-enable, the active-low transmit-ready and receive-ready DMA handshakes, and a multi-function pin.

The FIFOs, shifters, baud divider and register decoding sit outside the block and feed it. Every output is registered, so each pin reflects the inputs sampled at the previous rising clock edge. On the pad, the interrupt output-enable drives the three-state buffer of the interrupt pin.

Top module: `uart_pin_ctrl`

## Requirements
- R1: One clock after the inputs are sampled, `irq_o` is 1 exactly when `mcr_irq_en` is 1 and at least one pending source has its enable bit set. The bit order in `ier` and `irq_src` is: bit 0 receive data available, bit 1 transmit holding/FIFO empty, bit 2 receive line error, bit 3 modem status change.
- R2: `irq_oe` equals `mcr_irq_en` delayed by one clock. `irq_o` is never 1 while `irq_oe` is 0.
- R3: With `dma_mode` = 0, `txrdy_n` is 0 exactly when `tx_count` is 0, and 1 otherwise.
- R4: With `dma_mode` = 1, `txrdy_n` is 0 exactly when `tx_count` is below DEPTH, and 1 when the FIFO is full.
- R5: With `dma_mode` = 0, `rxrdy_n` is 0 exactly when `rx_count` is at least 1.
- R6: With `dma_mode` = 1, `rxrdy_n` is 0 exactly when `rx_count` is nonzero and not below `rx_trig`. It is 1 when the FIFO is empty or the trigger level has not been reached.
- R7: With `mf_sel` = 2'b00, `mf_o` is the inverse of the interrupt output-enable: 1 while disabled, 0 while enabled.
- R8: With `mf_sel` = 2'b01, `mf_o` carries `baud16` delayed by one clock.
- R9: With `mf_sel` = 2'b10, `mf_o` equals the receive-ready level that `rxrdy_n` shows in the same cycle.
- R10: With `mf_sel` = 2'b11 (reserved), `mf_o` is 1.
- R11: While `rst` is 1, `irq_o` = 0, `irq_oe` = 0, `txrdy_n` = 1, `rxrdy_n` = 1 and `mf_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_trig | input | CNT_W | Programmed receive trigger level |
| dma_mode | input | 1 | 0 = single transfer, 1 = block transfer |
| ier | input | 4 | Interrupt-enable bits |
| irq_src | input | 4 | Pending interrupt conditions |
| mcr_irq_en | input | 1 | Modem-control bit 3, interrupt output enable |
| mf_sel | input | 2 | Multi-function pin select |
| baud16 | input | 1 | 16x baud clock |
| irq_o | output | 1 | Interrupt, active high |
| irq_oe | output | 1 | Interrupt pin output enable |
| txrdy_n | output | 1 | Transmit ready, active low |
| rxrdy_n | output | 1 | Receive ready, active low |
| mf_o | output | 1 | Multi-function pin |

## Verification
The hardest corner is block-transfer receive-ready near the threshold: a count one below the trigger, exactly at it, and the trigger value 0 with an empty FIFO. The stimulus sweeps every count against several trigger levels in both DMA modes. The multi-function pin in baud mode only shows the one-clock delay if the baud input changes on every cycle, so the stimulus toggles it each clock and compares against the previous value.

// File: rtl/uart_pin_pkg.sv
package uart_pin_pkg;

    typedef enum logic [1:0] {
        MF_OP2  = 2'b00,
        MF_BAUD = 2'b01,
        MF_RXRDY = 2'b10,
        MF_RSVD = 2'b11
    } mf_sel_e;

    typedef struct packed {
        logic irq;
        logic irq_oe;
        logic txrdy_n;
        logic rxrdy_n;
        logic mf;
    } pins_t;

    localparam pins_t PINS_RESET = '{irq: 1'b0, irq_oe: 1'b0, txrdy_n: 1'b1,
                                     rxrdy_n: 1'b1, mf: 1'b1};

endpackage

// File: rtl/ucsp_irq_gate.sv
module ucsp_irq_gate #(
    parameter int N_SRC = 4
) (
    input  logic [N_SRC-1:0] ier,
    input  logic [N_SRC-1:0] src,
    input  logic             gate,
    output logic             irq
);
    logic [N_SRC-1:0] hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = ier[i] & src[i];
    end

    assign irq = gate & (|hit);
endmodule

// File: rtl/ucsp_dma_ready.sv
module ucsp_dma_ready #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             dma_mode,
    output logic             txrdy_n,
    output logic             rxrdy_n
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic tx_empty, tx_room, rx_any, rx_trig_hit;

    always_comb begin
        tx_empty    = (tx_count == '0);
        tx_room     = (tx_count < FULL);
        rx_any      = (rx_count != '0);
        rx_trig_hit = rx_any && (rx_count >= rx_trig);
        if (dma_mode) begin
            txrdy_n = ~tx_room;
            rxrdy_n = ~rx_trig_hit;
        end else begin
            txrdy_n = ~tx_empty;
            rxrdy_n = ~rx_any;
        end
    end
endmodule

// File: rtl/ucsp_mf_mux.sv
module ucsp_mf_mux
    import uart_pin_pkg::*;
(
    input  mf_sel_e sel,
    input  logic    op2,
    input  logic    baud,
    input  logic    rxrdy_n,
    output logic    mf
);
    always_comb begin
        unique case (sel)
            MF_OP2:   mf = op2;
            MF_BAUD:  mf = baud;
            MF_RXRDY: mf = rxrdy_n;
            default:  mf = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_pin_ctrl.sv
module uart_pin_ctrl
    import uart_pin_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int N_SRC = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             dma_mode,
    input  logic [N_SRC-1:0] ier,
    input  logic [N_SRC-1:0] irq_src,
    input  logic             mcr_irq_en,
    input  logic [1:0]       mf_sel,
    input  logic             baud16,
    output logic             irq_o,
    output logic             irq_oe,
    output logic             txrdy_n,
    output logic             rxrdy_n,
    output logic             mf_o
);
    pins_t pins_d, pins_q;
    logic  irq_c, txrdy_c, rxrdy_c, mf_c;

    ucsp_irq_gate #(.N_SRC(N_SRC)) u_irq (
        .ier  (ier),
        .src  (irq_src),
        .gate (mcr_irq_en),
        .irq  (irq_c)
    );

    ucsp_dma_ready #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rdy (
        .tx_count (tx_count),
        .rx_count (rx_count),
        .rx_trig  (rx_trig),
        .dma_mode (dma_mode),
        .txrdy_n  (txrdy_c),
        .rxrdy_n  (rxrdy_c)
    );

    ucsp_mf_mux u_mf (
        .sel     (mf_sel_e'(mf_sel)),
        .op2     (~mcr_irq_en),
        .baud    (baud16),
        .rxrdy_n (rxrdy_c),
        .mf      (mf_c)
    );

    always_comb begin
        pins_d         = pins_q;
        pins_d.irq     = irq_c;
        pins_d.irq_oe  = mcr_irq_en;
        pins_d.txrdy_n = txrdy_c;
        pins_d.rxrdy_n = rxrdy_c;
        pins_d.mf      = mf_c;
    end

    always_ff @(posedge clk) begin
        if (rst) pins_q <= PINS_RESET;
        else     pins_q <= pins_d;
    end

    assign irq_o   = pins_q.irq;
    assign irq_oe  = pins_q.irq_oe;
    assign txrdy_n = pins_q.txrdy_n;
    assign rxrdy_n = pins_q.rxrdy_n;
    assign mf_o    = pins_q.mf;
endmodule

// File: rtl/uart_pin_ctrl_chk.sv
module uart_pin_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             dma_mode,
    input logic             mcr_irq_en,
    input logic [1:0]       mf_sel,
    input logic             irq_o,
    input logic             irq_oe,
    input logic             txrdy_n,
    input logic             rxrdy_n,
    input logic             mf_o
);
    logic armed_q;
    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    // R2
    irq_needs_oe_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        irq_o |-> irq_oe);

    // R2
    oe_follows_mcr_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        irq_oe == $past(mcr_irq_en));

    // R4
    tx_full_busy_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(dma_mode && tx_count == CNT_W'(DEPTH)) |-> txrdy_n);

    // R5
    rx_empty_idle_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(rx_count == '0) |-> rxrdy_n);

    // R7
    op2_inverse_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(mf_sel == 2'b00) |-> (mf_o == !irq_oe));

    // R9
    mf_rxrdy_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(mf_sel == 2'b10) |-> (mf_o == rxrdy_n));

    // R10
    mf_reserved_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(mf_sel == 2'b11) |-> mf_o);

    // R11
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!irq_o && !irq_oe && txrdy_n && rxrdy_n && mf_o));
endmodule

bind uart_pin_ctrl uart_pin_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_count   (tx_count),
    .rx_count   (rx_count),
    .dma_mode   (dma_mode),
    .mcr_irq_en (mcr_irq_en),
    .mf_sel     (mf_sel),
    .irq_o      (irq_o),
    .irq_oe     (irq_oe),
    .txrdy_n    (txrdy_n),
    .rxrdy_n    (rxrdy_n),
    .mf_o       (mf_o)
);

// File: tb/uart_pin_ctrl_tb.sv
module uart_pin_ctrl_tb;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] tx_count = '0, rx_count = '0, rx_trig = '0;
    logic             dma_mode = 1'b0;
    logic [3:0]       ier = '0, irq_src = '0;
    logic             mcr_irq_en = 1'b0;
    logic [1:0]       mf_sel = 2'b00;
    logic             baud16 = 1'b0;
    logic             irq_o, irq_oe, txrdy_n, rxrdy_n, mf_o;

    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    uart_pin_ctrl #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .tx_count(tx_count), .rx_count(rx_count),
        .rx_trig(rx_trig), .dma_mode(dma_mode), .ier(ier), .irq_src(irq_src),
        .mcr_irq_en(mcr_irq_en), .mf_sel(mf_sel), .baud16(baud16),
        .irq_o(irq_o), .irq_oe(irq_oe), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n),
        .mf_o(mf_o)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Inputs change at the falling edge; outputs are read 1 ns after the next rising edge.
    task automatic step();
        @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        mcr_irq_en = 1'b1; ier = 4'hF; irq_src = 4'hF; rx_count = 5;
        mf_sel = 2'b00;
        step();
        check("R11 irq", irq_o, 1'b0);
        check("R11 oe", irq_oe, 1'b0);
        check("R11 txrdy", txrdy_n, 1'b1);
        check("R11 rxrdy", rxrdy_n, 1'b1);
        check("R11 mf", mf_o, 1'b1);
        @(negedge clk);
        rst = 1'b0; mcr_irq_en = 1'b0; ier = '0; irq_src = '0; rx_count = '0;
    endtask

    task automatic t_irq();
        for (int g = 0; g < 2; g++)
            for (int e = 0; e < 16; e++)
                for (int s = 0; s < 16; s += 5) begin
                    @(negedge clk);
                    mcr_irq_en = g[0]; ier = e[3:0]; irq_src = s[3:0];
                    step();
                    check("R1 irq", irq_o, g[0] && ((e[3:0] & s[3:0]) != 0));
                    check("R2 oe", irq_oe, g[0]);
                end
    endtask

    task automatic t_tx();
        for (int m = 0; m < 2; m++)
            for (int c = 0; c <= DEPTH; c++) begin
                @(negedge clk);
                dma_mode = m[0]; tx_count = CNT_W'(c);
                step();
                if (m == 0) check("R3 txrdy", txrdy_n, c != 0);
                else        check("R4 txrdy", txrdy_n, c >= DEPTH);
            end
    endtask

    task automatic t_rx();
        int trigs[5] = '{0, 1, 4, 8, 14};
        for (int m = 0; m < 2; m++)
            foreach (trigs[k])
                for (int c = 0; c <= DEPTH; c++) begin
                    @(negedge clk);
                    dma_mode = m[0]; rx_trig = CNT_W'(trigs[k]); rx_count = CNT_W'(c);
                    step();
                    if (m == 0) check("R5 rxrdy", rxrdy_n, c == 0);
                    else        check("R6 rxrdy", rxrdy_n, !(c != 0 && c >= trigs[k]));
                end
    endtask

    task automatic t_mf();
        // R7: OP2 select
        for (int g = 0; g < 2; g++) begin
            @(negedge clk); mf_sel = 2'b00; mcr_irq_en = g[0];
            step();
            check("R7 mf", mf_o, !g[0]);
        end
        // R8: baud toggled every clock
        @(negedge clk); mf_sel = 2'b01;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); baud16 = i[0];
            step();
            check("R8 mf", mf_o, i[0]);
        end
        // R9: receive-ready on the pin
        dma_mode = 1'b1; rx_trig = 4;
        for (int c = 2; c < 7; c++) begin
            @(negedge clk); mf_sel = 2'b10; rx_count = CNT_W'(c);
            step();
            check("R9 mf", mf_o, c < 4);
            check("R9 match", mf_o, rxrdy_n);
        end
        // R10: reserved code drives 1 whatever else changes
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); mf_sel = 2'b11; baud16 = 1'b0; mcr_irq_en = 1'b1;
            rx_count = CNT_W'(i * 5);
            step();
            check("R10 mf", mf_o, 1'b1);
        end
    endtask

    initial begin
        t_reset();
        t_irq();
        t_tx();
        t_rx();
        t_mf();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule